// File: doc/BRIEF.md
# Partial-Access General Register File

This block is a bank of sixteen 64-bit general-purpose registers. Each register can be reached as a whole 64-bit value or through narrower views: a 32-bit view on bits 31:0, a 16-bit view on bits 15:0, a low-byte view on bits 7:0, and, for registers 0 to 3 only, a high-byte view on bits 15:8. An execution pipeline uses it as its architectural register storage. There is one write port and two independent read ports, and each port has its own register index, access size and high-byte select.

Reads are combinational and return the selected view zero-extended to 64 bits. How a write is stored depends on its size. A full write replaces the register. A 32-bit write stores its data and clears the upper half. A 16-bit or byte write merges into the old contents. A high-byte write to a register that has no high-byte view is refused, and a one-cycle error pulse is raised. When a read port and the write port name the same register in the same cycle, the read returns the value the write is about to store.

Top module: `gpr_file`

## Requirements
- R1: While rst_ni is low, every register is asynchronously cleared to zero and illegal_o is low.
- R2: A write with size 2'b11 stores all 64 bits of wr_data_i at the rising clock edge.
- R3: A write with size 2'b10 stores wr_data_i[31:0] in bits 31:0 and clears bits 63:32.
- R4: A write with size 2'b01 stores wr_data_i[15:0] in bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with size 2'b00 and the high select low stores wr_data_i[7:0] in bits 7:0 of any register and leaves bits 63:8 unchanged.
- R6: A write with size 2'b00 and the high select high, to register 0, 1, 2 or 3, stores wr_data_i[7:0] in bits 15:8 and leaves every other bit unchanged.
- R7: A write with size 2'b00 and the high select high, to register 4 or above, leaves every register unchanged. illegal_o is then high for exactly the one cycle that follows that clock edge.
- R8: A read returns, zero-extended to 64 bits, bits 63:0 for size 2'b11, bits 31:0 for 2'b10, bits 15:0 for 2'b01, bits 7:0 for 2'b00 with the high select low, and bits 15:8 for 2'b00 with the high select high on registers 0 to 3.
- R9: A read with size 2'b00 and the high select high, from register 4 or above, returns zero.
- R10: The high select has no effect on reads or writes whose size is not 2'b00.
- R11: When a read port names the register that a legal write targets in the same cycle, it returns the value after that write, with merge or zero-extension applied. This holds on both ports.
- R12: With wr_en_i low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 4 | Register written |
| wr_size_i | input | 2 | Write size: 00 byte, 01 16-bit, 10 32-bit, 11 64-bit |
| wr_hi_i | input | 1 | Byte write targets bits 15:8 |
| wr_data_i | input | 64 | Write data, right-aligned |
| rd_a_idx_i | input | 4 | Register read on port A |
| rd_a_size_i | input | 2 | Read size on port A, same encoding |
| rd_a_hi_i | input | 1 | Port A byte read from bits 15:8 |
| rd_a_data_o | output | 64 | Port A data, zero-extended |
| rd_b_idx_i | input | 4 | Register read on port B |
| rd_b_size_i | input | 2 | Read size on port B, same encoding |
| rd_b_hi_i | input | 1 | Port B byte read from bits 15:8 |
| rd_b_data_o | output | 64 | Port B data, zero-extended |
| illegal_o | output | 1 | One-cycle pulse after a refused write |

## Verification
Reads are combinational, so a register that holds a wrong value shows up on a full-width read in the first cycle after the faulty edge. A merge that touches the wrong bits shows up only when the neighbouring bits are read. For that reason the bench preloads distinct patterns around each narrow write and reads the full register back. A broken bypass shows a stale value only during the writing cycle itself, so the bench samples both ports in that cycle. A refused write that leaks into storage, or an error pulse of the wrong length, shows up one cycle after the edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_FULL = 2'b11
  } acc_size_e;

  localparam int BYTE_BITS = 8;
  localparam int HALF_BITS = 16;
endpackage

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  logic [1:0]      size_i,
  input  logic            hi_i,
  output logic [XLEN-1:0] new_o
);
  localparam int WORD_BITS = XLEN / 2;

  always_comb begin
    case (acc_size_e'(size_i))
      ACC_FULL: new_o = data_i;
      ACC_WORD: new_o = {{(XLEN-WORD_BITS){1'b0}}, data_i[WORD_BITS-1:0]};
      ACC_HALF: new_o = {old_i[XLEN-1:HALF_BITS], data_i[HALF_BITS-1:0]};
      default: begin
        if (hi_i)
          new_o = {old_i[XLEN-1:HALF_BITS], data_i[BYTE_BITS-1:0], old_i[BYTE_BITS-1:0]};
        else
          new_o = {old_i[XLEN-1:BYTE_BITS], data_i[BYTE_BITS-1:0]};
      end
    endcase
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int XLEN     = 64,
  parameter int HI_REGS  = 4,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [1:0]                    size_i,
  input  logic                          hi_i,
  input  logic                          byp_en_i,
  input  logic [IDX_W-1:0]              byp_idx_i,
  input  logic [XLEN-1:0]               byp_val_i,
  output logic [XLEN-1:0]               data_o
);
  localparam int WORD_BITS = XLEN / 2;

  logic [XLEN-1:0] src;

  always_comb begin
    // same-cycle write wins over stored value
    src    = (byp_en_i && (byp_idx_i == idx_i)) ? byp_val_i : regs_i[idx_i];
    data_o = '0;
    case (acc_size_e'(size_i))
      ACC_FULL: data_o = src;
      ACC_WORD: data_o[WORD_BITS-1:0] = src[WORD_BITS-1:0];
      ACC_HALF: data_o[HALF_BITS-1:0] = src[HALF_BITS-1:0];
      default: begin
        if (!hi_i)
          data_o[BYTE_BITS-1:0] = src[BYTE_BITS-1:0];
        else if (int'(idx_i) < HI_REGS)
          data_o[BYTE_BITS-1:0] = src[HALF_BITS-1:BYTE_BITS];
      end
    endcase
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NUM_REGS = 16,
  parameter int XLEN     = 64,
  parameter int IDX_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [XLEN-1:0]               val_i,
  output logic [NUM_REGS-1:0][XLEN-1:0] regs_o
);
  logic [XLEN-1:0] q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q[g] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))   q[g] <= val_i;
    end
    assign regs_o[g] = q[g];
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int  NUM_REGS = 16,
  parameter int  XLEN     = 64,
  parameter int  HI_REGS  = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_size_i,
  input  logic             wr_hi_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [1:0]       rd_a_size_i,
  input  logic             rd_a_hi_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic [1:0]       rd_b_size_i,
  input  logic             rd_b_hi_i,
  output logic [XLEN-1:0]  rd_b_data_o,
  output logic             illegal_o
);
  localparam int NUM_RD    = 2;
  localparam int WORD_BITS = XLEN / 2;

  logic [NUM_REGS-1:0][XLEN-1:0] regs;
  logic [XLEN-1:0]               wr_val;
  logic                          bad_wr, wr_ok, illegal_q;

  assign bad_wr = wr_en_i && (acc_size_e'(wr_size_i) == ACC_BYTE) && wr_hi_i
                  && (int'(wr_idx_i) >= HI_REGS);
  assign wr_ok  = wr_en_i && !bad_wr;

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .old_i  (regs[wr_idx_i]),
    .data_i (wr_data_i),
    .size_i (wr_size_i),
    .hi_i   (wr_hi_i),
    .new_o  (wr_val)
  );

  gpr_bank #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .IDX_W(IDX_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok),
    .idx_i  (wr_idx_i),
    .val_i  (wr_val),
    .regs_o (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= bad_wr;
  end
  assign illegal_o = illegal_q;

  logic [IDX_W-1:0] rd_idx  [NUM_RD];
  logic [1:0]       rd_size [NUM_RD];
  logic             rd_hi   [NUM_RD];
  logic [XLEN-1:0]  rd_data [NUM_RD];

  assign rd_idx[0]  = rd_a_idx_i;
  assign rd_size[0] = rd_a_size_i;
  assign rd_hi[0]   = rd_a_hi_i;
  assign rd_idx[1]  = rd_b_idx_i;
  assign rd_size[1] = rd_b_size_i;
  assign rd_hi[1]   = rd_b_hi_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port #(
      .NUM_REGS(NUM_REGS), .XLEN(XLEN), .HI_REGS(HI_REGS), .IDX_W(IDX_W)
    ) u_rd (
      .regs_i    (regs),
      .idx_i     (rd_idx[p]),
      .size_i    (rd_size[p]),
      .hi_i      (rd_hi[p]),
      .byp_en_i  (wr_ok),
      .byp_idx_i (wr_idx_i),
      .byp_val_i (wr_val),
      .data_o    (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b11) |=> regs[$past(wr_idx_i)] == $past(wr_data_i));

  assert_word_zext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b10) |=>
      (regs[$past(wr_idx_i)][XLEN-1:WORD_BITS] == '0) &&
      (regs[$past(wr_idx_i)][WORD_BITS-1:0] == $past(wr_data_i[WORD_BITS-1:0])));

  assert_half_merge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b01) |=>
      regs[$past(wr_idx_i)][XLEN-1:16] == $past(regs[wr_idx_i][XLEN-1:16]));

  assert_lo_byte_merge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b00 && !wr_hi_i) |=>
      regs[$past(wr_idx_i)][XLEN-1:8] == $past(regs[wr_idx_i][XLEN-1:8]));

  assert_refused_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b00 && wr_hi_i && int'(wr_idx_i) >= HI_REGS) |=>
      illegal_o && (regs == $past(regs)));

  assert_illegal_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_size_i == 2'b00 && wr_hi_i && int'(wr_idx_i) >= HI_REGS) |=> !illegal_o);

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> regs == $past(regs));

  assert_bypass_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b11 && rd_a_size_i == 2'b11 && rd_a_idx_i == wr_idx_i)
      |-> rd_a_data_o == wr_data_i);
endmodule

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_hi = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  a_idx = '0, b_idx = '0;
  logic [1:0]  a_size = '0, b_size = '0;
  logic        a_hi = 1'b0, b_hi = 1'b0;
  logic [63:0] a_data, b_data;
  logic        illegal;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [63:0] mdl [16];

  always #2.5 clk = ~clk;

  gpr_file u_gpr_file (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_size_i(wr_size), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .rd_a_idx_i(a_idx), .rd_a_size_i(a_size), .rd_a_hi_i(a_hi), .rd_a_data_o(a_data),
    .rd_b_idx_i(b_idx), .rd_b_size_i(b_size), .rd_b_hi_i(b_hi), .rd_b_data_o(b_data),
    .illegal_o(illegal)
  );

  // expected store per R2..R6, R10
  function automatic logic [63:0] f_merge(logic [63:0] old, logic [63:0] d, logic [1:0] sz, logic hi);
    case (sz)
      2'b11: return d;
      2'b10: return {32'h0, d[31:0]};
      2'b01: return {old[63:16], d[15:0]};
      default: return hi ? {old[63:16], d[7:0], old[7:0]} : {old[63:8], d[7:0]};
    endcase
  endfunction

  // expected read per R8, R9, R10
  function automatic logic [63:0] f_view(logic [63:0] v, int idx, logic [1:0] sz, logic hi);
    case (sz)
      2'b11: return v;
      2'b10: return {32'h0, v[31:0]};
      2'b01: return {48'h0, v[15:0]};
      default: begin
        if (!hi) return {56'h0, v[7:0]};
        if (idx < 4) return {56'h0, v[15:8]};
        return 64'h0;
      end
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [1:0] sz, logic hi, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_size = sz; wr_hi = hi; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (!(sz == 2'b00 && hi && idx >= 4)) mdl[idx] = f_merge(mdl[idx], d, sz, hi);
  endtask

  task automatic rd(string req, int idx, logic [1:0] sz, logic hi);
    @(negedge clk);
    a_idx = 4'(idx); a_size = sz; a_hi = hi;
    b_idx = 4'(idx); b_size = sz; b_hi = hi;
    #1;
    check(req, a_data, f_view(mdl[idx], idx, sz, hi));
    check(req, b_data, f_view(mdl[idx], idx, sz, hi));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) rd("R1", i, 2'b11, 1'b0);
    check("R1", 64'(illegal), 64'h0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) wr(i, 2'b11, 1'b0, {32'hA5A5_0000 + 32'(i), 32'hC3C3_F0F0 ^ 32'(i*7)});
    for (int i = 0; i < 16; i++) rd("R2", i, 2'b11, 1'b0);
  endtask

  task automatic t_word();
    wr(5, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(5, 2'b10, 1'b0, 64'h1234_5678_8765_4321);
    rd("R3", 5, 2'b11, 1'b0);
    check("R3", mdl[5], 64'h0000_0000_8765_4321);
  endtask

  task automatic t_half();
    wr(9, 2'b11, 1'b0, 64'h0102_0304_0506_0708);
    wr(9, 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_BEEF);
    rd("R4", 9, 2'b11, 1'b0);
    check("R4", mdl[9], 64'h0102_0304_0506_BEEF);
  endtask

  task automatic t_lo_byte();
    for (int i = 0; i < 16; i += 5) begin
      wr(i, 2'b11, 1'b0, 64'h1111_2222_3333_4444);
      wr(i, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FF9C);
      rd("R5", i, 2'b11, 1'b0);
    end
    check("R5", mdl[15], 64'h1111_2222_3333_449C);
  endtask

  task automatic t_hi_byte();
    for (int i = 0; i < 4; i++) begin
      wr(i, 2'b11, 1'b0, 64'hDEAD_BEEF_CAFE_F00D);
      wr(i, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FF5A);
      rd("R6", i, 2'b11, 1'b0);
    end
    check("R6", mdl[3], 64'hDEAD_BEEF_CAFE_5A0D);
  endtask

  task automatic t_illegal();
    wr(12, 2'b11, 1'b0, 64'h7777_6666_5555_4444);
    wr(12, 2'b00, 1'b1, 64'h0000_0000_0000_00EE);
    check("R7", 64'(illegal), 64'h1);
    @(posedge clk); #1;
    check("R7", 64'(illegal), 64'h0);
    rd("R7", 12, 2'b11, 1'b0);
    check("R7", mdl[12], 64'h7777_6666_5555_4444);
    wr(4, 2'b00, 1'b1, 64'h11);
    check("R7", 64'(illegal), 64'h1);
    rd("R7", 4, 2'b11, 1'b0);
  endtask

  task automatic t_views();
    wr(2, 2'b11, 1'b0, 64'hFEDC_BA98_7654_3210);
    rd("R8", 2, 2'b11, 1'b0);
    rd("R8", 2, 2'b10, 1'b0);
    rd("R8", 2, 2'b01, 1'b0);
    rd("R8", 2, 2'b00, 1'b0);
    rd("R8", 2, 2'b00, 1'b1);
    check("R8", a_data, 64'h32);
    wr(7, 2'b11, 1'b0, 64'hFEDC_BA98_7654_3210);
    rd("R9", 7, 2'b00, 1'b1);
    check("R9", a_data, 64'h0);
    rd("R8", 7, 2'b00, 1'b0);
  endtask

  task automatic t_hi_ignored();
    wr(10, 2'b11, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD);
    wr(10, 2'b01, 1'b1, 64'h0000_0000_0000_1357);
    rd("R10", 10, 2'b11, 1'b0);
    check("R10", 64'(illegal), 64'h0);
    rd("R10", 10, 2'b10, 1'b1);
    rd("R10", 10, 2'b11, 1'b1);
    wr(1, 2'b10, 1'b1, 64'h9999_8888_7777_6666);
    rd("R10", 1, 2'b11, 1'b0);
  endtask

  task automatic t_idle();
    wr(6, 2'b11, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F);
    @(negedge clk);
    wr_idx = 4'd6; wr_size = 2'b11; wr_data = 64'h1; wr_en = 1'b0;
    @(posedge clk); #1;
    rd("R12", 6, 2'b11, 1'b0);
  endtask

  task automatic byp(int idx, logic [1:0] sz, logic hi, logic [63:0] d, logic [1:0] rsz_a, logic [1:0] rsz_b);
    logic [63:0] nv;
    nv = f_merge(mdl[idx], d, sz, hi);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_size = sz; wr_hi = hi; wr_data = d;
    a_idx = 4'(idx); a_size = rsz_a; a_hi = 1'b0;
    b_idx = 4'(idx); b_size = rsz_b; b_hi = 1'b0;
    #1;
    check("R11", a_data, f_view(nv, idx, rsz_a, 1'b0));
    check("R11", b_data, f_view(nv, idx, rsz_b, 1'b0));
    @(posedge clk);
    #1 wr_en = 1'b0;
    mdl[idx] = nv;
  endtask

  task automatic t_bypass();
    wr(0, 2'b11, 1'b0, 64'h5555_5555_5555_5555);
    byp(0, 2'b00, 1'b1, 64'hC7, 2'b11, 2'b01);
    byp(0, 2'b10, 1'b0, 64'hFFFF_0000_1234_ABCD, 2'b11, 2'b10);
    byp(13, 2'b11, 1'b0, 64'h0BAD_F00D_DEAD_C0DE, 2'b11, 2'b11);
    rd("R11", 0, 2'b11, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_full();
    t_word();
    t_half();
    t_lo_byte();
    t_hi_byte();
    t_illegal();
    t_views();
    t_hi_ignored();
    t_idle();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule